// File: doc/BRIEF.md
# HDLC Transmit Framer with Buffer Events

This block turns bytes loaded into a small on-chip queue into a bit-oriented HDLC line signal. Software or a DMA engine writes the frame one byte at a time and marks where each buffer ends and where the frame ends. The block owns the whole line sequence. It asserts request-to-send and waits for clear-to-send. It then sends one opening flag plus a programmable number of extra flags, followed by the payload with zero-bit insertion. A single closing flag ends the frame, after which the line returns to idle. Any check bytes must already be present in the payload.

Each buffer can ask for a transmit-buffer event. The event timing depends on where the buffer sits in its frame. If the buffer does not end its frame, the event fires as soon as the buffer's final byte is accepted into the queue. If the buffer ends the frame, the event is held back until the last bit of the closing flag is placed on the line. The event is latched in an event bit that is cleared by writing one. A mask bit gates that event bit onto the interrupt output.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, txd is 1, rts is 0, txb_event is 0, irq is 0 and wr_ready is 1.
- R2: A frame starts only when its final byte (the one written with wr_frame_end=1) is in the queue. At that point rts goes to 1. No flag bit appears on txd until a bit tick with cts=1 has been seen. While rts is 0, txd stays 1.
- R3: A frame opens with 1 + extra_flags flags. Each flag is the byte 0x7E sent least significant bit first, which gives the line pattern 0,1,1,1,1,1,1,0.
- R4: Payload bytes are sent least significant bit first, one bit per cycle with bit_en=1. After five consecutive payload ones, a single 0 is inserted. The run of ones carries across byte boundaries and is also checked after the final payload bit, before the closing flag.
- R5: Flags are never bit-stuffed. Exactly one closing flag follows the final payload bit (or the stuffed 0 that follows it).
- R6: On the bit tick after the last closing-flag bit, txd returns to 1 and rts returns to 0.
- R7: Writing a byte with wr_buf_end=1, wr_frame_end=0 and wr_int_en=1 sets txb_event in the following clock cycle.
- R8: For a frame-ending byte written with wr_int_en=1, txb_event is still 0 while the last closing-flag bit is first visible on txd. It is 1 from the next clock onward.
- R9: A buffer end written with wr_int_en=0 never sets txb_event.
- R10: A cycle with evt_clr=1 clears txb_event, unless a new event sets it in that same cycle, in which case the set wins.
- R11: irq equals txb_event AND the mask bit. The mask bit is loaded from mask_wd on a cycle with mask_we=1 and resets to 0.
- R12: wr_ready is 0 while the queue holds DEPTH bytes. Writes are accepted only while wr_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Line bit-time enable, one bit per asserted cycle |
| extra_flags | input | FLAG_W | Additional opening flags beyond the first |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to write |
| wr_buf_end | input | 1 | Byte is the last of its buffer |
| wr_frame_end | input | 1 | Byte is the last of its frame (also ends its buffer) |
| wr_int_en | input | 1 | Buffer requests a transmit-buffer event |
| wr_ready | output | 1 | Queue has room |
| cts | input | 1 | Clear-to-send, active high |
| rts | output | 1 | Request-to-send, active high |
| txd | output | 1 | Serial line data |
| evt_clr | input | 1 | Write-one-to-clear strobe for the event bit |
| mask_we | input | 1 | Load the mask bit |
| mask_wd | input | 1 | New mask value |
| txb_event | output | 1 | Latched transmit-buffer event |
| irq | output | 1 | Masked interrupt |

## Verification
The bench decodes the line and compares it bit by bit against a stream it builds itself. The payloads include all ones, the flag pattern used as data, and bytes that leave five ones at the very end of the frame. A framer that reset its ones-run at byte edges, stuffed inside flags, or skipped the final stuff before the closing flag would produce a mismatching stream.

The bench records the event bit at every bit tick to catch a last-buffer event that arrives early or late. It checks that a mid-frame buffer event appears right after the write and that a clear in the same cycle does not swallow it.

Further checks hold cts low to catch a framer that ignores the handshake, and leave a frame incomplete to catch one that starts too early. A final test fills the queue to catch wr_ready staying high.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam int unsigned STUFF_RUN = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_CTS,
        S_OPEN,
        S_DATA,
        S_CLOSE,
        S_DONE
    } tx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       eof;
        logic       irq;
    } q_entry_t;

endpackage

// File: rtl/hdlc_tx_queue.sv
module hdlc_tx_queue
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  q_entry_t push_ent,
    input  logic     pop,
    output q_entry_t head,
    output logic     full,
    output logic     frame_avail
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [CW-1:0] frames;
    } q_state_t;

    q_state_t q_q, q_d;
    q_entry_t mem_q [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) q_d.wp = bump(q_q.wp);
        if (pop)  q_d.rp = bump(q_q.rp);
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + CW'(1);
            2'b01:   q_d.cnt = q_q.cnt - CW'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
        case ({push && push_ent.eof, pop && head.eof})
            2'b10:   q_d.frames = q_q.frames + CW'(1);
            2'b01:   q_d.frames = q_q.frames - CW'(1);
            default: q_d.frames = q_q.frames;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[q_q.wp] <= push_ent;
    end

    assign head        = mem_q[q_q.rp];
    assign full        = (q_q.cnt == CW'(DEPTH));
    assign frame_avail = (q_q.frames != '0);

    // R12
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));

    // R2
    pop_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q_q.cnt != '0) && (q_q.frames != '0));

endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [FLAG_W-1:0] extra_flags,
    input  logic              cts,
    input  logic              frame_avail,
    input  q_entry_t          head,
    output logic              pop,
    output logic              txd,
    output logic              rts,
    output logic              txb_last
);

    typedef struct packed {
        tx_state_e         st;
        logic [7:0]        sh;
        logic              eof;
        logic              irq;
        logic [2:0]        idx;
        logic [FLAG_W-1:0] fcnt;
        logic [2:0]        ones;
        logic              txd;
        logic              rts;
        logic              txb;
    } ser_state_t;

    ser_state_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.txb = 1'b0;
        pop     = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                s_d.txd = 1'b1;
                s_d.rts = 1'b0;
                if (frame_avail) begin
                    s_d.st  = S_WAIT_CTS;
                    s_d.rts = 1'b1;
                end
            end
            S_WAIT_CTS: begin
                if (bit_en && cts) begin
                    s_d.st   = S_OPEN;
                    s_d.idx  = '0;
                    s_d.fcnt = extra_flags;
                end
            end
            S_OPEN: begin
                if (bit_en) begin
                    s_d.txd = FLAG_BYTE[s_q.idx];
                    if (s_q.idx == 3'd7) begin
                        s_d.idx = '0;
                        if (s_q.fcnt == '0) begin
                            s_d.st   = S_DATA;
                            s_d.sh   = head.data;
                            s_d.eof  = head.eof;
                            s_d.irq  = head.irq;
                            s_d.ones = '0;
                            pop      = 1'b1;
                        end else begin
                            s_d.fcnt = s_q.fcnt - FLAG_W'(1);
                        end
                    end else begin
                        s_d.idx = s_q.idx + 3'd1;
                    end
                end
            end
            S_DATA: begin
                if (bit_en) begin
                    if (s_q.ones == 3'(STUFF_RUN)) begin
                        s_d.txd  = 1'b0;
                        s_d.ones = '0;
                    end else begin
                        s_d.txd  = s_q.sh[s_q.idx];
                        s_d.ones = s_q.sh[s_q.idx] ? s_q.ones + 3'd1 : 3'd0;
                        if (s_q.idx == 3'd7) begin
                            s_d.idx = '0;
                            if (s_q.eof) begin
                                s_d.st = S_CLOSE;
                            end else begin
                                s_d.sh  = head.data;
                                s_d.eof = head.eof;
                                s_d.irq = head.irq;
                                pop     = 1'b1;
                            end
                        end else begin
                            s_d.idx = s_q.idx + 3'd1;
                        end
                    end
                end
            end
            S_CLOSE: begin
                if (bit_en) begin
                    if (s_q.ones == 3'(STUFF_RUN)) begin
                        s_d.txd  = 1'b0;
                        s_d.ones = '0;
                    end else begin
                        s_d.txd = FLAG_BYTE[s_q.idx];
                        if (s_q.idx == 3'd7) begin
                            s_d.idx = '0;
                            s_d.st  = S_DONE;
                            s_d.txb = s_q.irq;
                        end else begin
                            s_d.idx = s_q.idx + 3'd1;
                        end
                    end
                end
            end
            S_DONE: begin
                if (bit_en) begin
                    s_d.txd = 1'b1;
                    s_d.rts = 1'b0;
                    s_d.st  = S_IDLE;
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= S_IDLE;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd      = s_q.txd;
    assign rts      = s_q.rts;
    assign txb_last = s_q.txb;

    // R2
    line_low_needs_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.txd |-> s_q.rts);

    // R6
    rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.rts) |-> s_q.txd);

    // R4
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_DATA && bit_en && s_q.ones == 3'(STUFF_RUN)) |=> !s_q.txd);

endmodule

// File: rtl/hdlc_tx_event.sv
module hdlc_tx_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_buf,
    input  logic set_frame,
    input  logic clr,
    input  logic mask_we,
    input  logic mask_wd,
    output logic evt,
    output logic irq
);

    typedef struct packed {
        logic evt;
        logic mask;
    } ev_state_t;

    ev_state_t e_q, e_d;

    always_comb begin
        e_d      = e_q;
        e_d.evt  = (e_q.evt && !clr) || set_buf || set_frame;
        if (mask_we) e_d.mask = mask_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign evt = e_q.evt;
    assign irq = e_q.evt && e_q.mask;

    // R10
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_buf && !set_frame) |=> !e_q.evt);

    // R7
    evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.evt) |-> $past(set_buf || set_frame));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [FLAG_W-1:0] extra_flags,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_buf_end,
    input  logic              wr_frame_end,
    input  logic              wr_int_en,
    output logic              wr_ready,
    input  logic              cts,
    output logic              rts,
    output logic              txd,
    input  logic              evt_clr,
    input  logic              mask_we,
    input  logic              mask_wd,
    output logic              txb_event,
    output logic              irq
);

    logic     full;
    logic     frame_avail;
    logic     push;
    logic     pop;
    logic     set_buf;
    logic     txb_last;
    q_entry_t push_ent;
    q_entry_t head;

    assign wr_ready      = !full;
    assign push          = wr_en && !full;
    assign push_ent.data = wr_data;
    assign push_ent.eof  = wr_frame_end;
    assign push_ent.irq  = wr_int_en && (wr_buf_end || wr_frame_end);
    assign set_buf       = push && wr_buf_end && !wr_frame_end && wr_int_en;

    hdlc_tx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_ent    (push_ent),
        .pop         (pop),
        .head        (head),
        .full        (full),
        .frame_avail (frame_avail)
    );

    hdlc_tx_serializer #(.FLAG_W(FLAG_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .extra_flags (extra_flags),
        .cts         (cts),
        .frame_avail (frame_avail),
        .head        (head),
        .pop         (pop),
        .txd         (txd),
        .rts         (rts),
        .txb_last    (txb_last)
    );

    hdlc_tx_event u_event (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_buf   (set_buf),
        .set_frame (txb_last),
        .clr       (evt_clr),
        .mask_we   (mask_we),
        .mask_wd   (mask_wd),
        .evt       (txb_event),
        .irq       (irq)
    );

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |-> !push);

endmodule

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;

    localparam int DEPTH  = 16;
    localparam int FLAG_W = 4;
    localparam int MAXB   = 512;

    // vector: {extra_flags[19:16], byte0[15:8], byte1[7:0]}
    localparam logic [19:0] VEC [0:5] = '{
        {4'd0, 8'h00, 8'h00},
        {4'd1, 8'hFF, 8'hFF},
        {4'd2, 8'h7E, 8'h7E},
        {4'd0, 8'h1F, 8'hF8},
        {4'd3, 8'hA5, 8'h3C},
        {4'd1, 8'hF8, 8'h1F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic [FLAG_W-1:0] extra_flags = '0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic wr_buf_end = 1'b0;
    logic wr_frame_end = 1'b0;
    logic wr_int_en = 1'b0;
    logic wr_ready;
    logic cts = 1'b0;
    logic rts;
    logic txd;
    logic evt_clr = 1'b0;
    logic mask_we = 1'b0;
    logic mask_wd = 1'b0;
    logic txb_event;
    logic irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic cap_bit [0:MAXB-1];
    logic cap_evt [0:MAXB-1];
    logic cap_rts [0:MAXB-1];
    int   ncap = 0;
    bit   cap_on = 0;

    logic [7:0] fb [0:7];
    logic exp_s [0:MAXB-1];

    always #5 clk = ~clk;

    hdlc_tx_framer #(.DEPTH(DEPTH), .FLAG_W(FLAG_W)) u_hdlc_tx_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .extra_flags(extra_flags),
        .wr_en(wr_en), .wr_data(wr_data), .wr_buf_end(wr_buf_end),
        .wr_frame_end(wr_frame_end), .wr_int_en(wr_int_en), .wr_ready(wr_ready),
        .cts(cts), .rts(rts), .txd(txd), .evt_clr(evt_clr), .mask_we(mask_we),
        .mask_wd(mask_wd), .txb_event(txb_event), .irq(irq)
    );

    // bit tick: one cycle in four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            bit_en = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    // line monitor: sample after each bit-tick edge
    initial begin
        logic t;
        forever begin
            @(posedge clk);
            t = bit_en;
            @(negedge clk);
            if (t && cap_on && ncap < MAXB) begin
                cap_bit[ncap] = txd;
                cap_evt[ncap] = txb_event;
                cap_rts[ncap] = rts;
                ncap++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] d, input logic be, input logic fe,
                             input logic ie, input logic clr);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_buf_end = be; wr_frame_end = fe;
        wr_int_en = ie; evt_clr = clr;
        @(negedge clk);
        wr_en = 1'b0; wr_buf_end = 1'b0; wr_frame_end = 1'b0;
        wr_int_en = 1'b0; evt_clr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
    endtask

    // runs the frame already queued, then checks line, rts and event timing
    task automatic run_check(input int nb, input int extra, input bit ev_exp);
        int ne = 0;
        int ones = 0;
        int first = -1;
        int mism = 0;
        int wd = 0;
        for (int f = 0; f <= extra; f++)
            for (int i = 0; i < 8; i++) begin exp_s[ne] = 8'h7E >> i; ne++; end
        for (int b = 0; b < nb; b++)
            for (int i = 0; i < 8; i++) begin
                exp_s[ne] = fb[b][i]; ne++;
                ones = fb[b][i] ? ones + 1 : 0;
                if (ones == 5) begin exp_s[ne] = 1'b0; ne++; ones = 0; end
            end
        for (int i = 0; i < 8; i++) begin exp_s[ne] = 8'h7E >> i; ne++; end
        cts = 1'b1;
        while (!rts && wd < 400) begin @(negedge clk); wd++; end
        while (rts && wd < 4000) begin @(negedge clk); wd++; end
        repeat (12) @(negedge clk);
        cap_on = 0;
        for (int k = 0; k < ncap; k++) if (first < 0 && cap_bit[k] == 1'b0) first = k;
        if (first < 0 || first + ne + 1 >= ncap) begin
            check(1'b0, "R3/R4/R5 frame found", first, 0);
            return;
        end
        for (int k = 0; k < ne; k++) if (cap_bit[first + k] !== exp_s[k]) mism++;
        // R3 R4 R5: full line stream
        check(mism == 0, "R3/R4/R5 line stream mismatched bits", mism, 0);
        // R6: line idle and rts released on next tick
        check(cap_bit[first + ne] === 1'b1 && cap_rts[first + ne] === 1'b0,
              "R6 idle after close", {cap_bit[first + ne], cap_rts[first + ne]}, 2);
        if (ev_exp) begin
            // R8: not yet set while last flag bit first shows, set afterwards
            check(cap_evt[first + ne - 1] === 1'b0 && cap_evt[first + ne] === 1'b1,
                  "R8 last-buffer event timing",
                  {cap_evt[first + ne - 1], cap_evt[first + ne]}, 1);
        end else begin
            // R9: no event when the buffer did not ask for one
            check(cap_evt[first + ne] === 1'b0, "R9 no event", cap_evt[first + ne], 0);
        end
    endtask

    task automatic start_cap();
        ncap = 0; cap_on = 1;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int zeros;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd === 1'b1, "R1 txd", txd, 1);
        check(rts === 1'b0, "R1 rts", rts, 0);
        check(txb_event === 1'b0 && irq === 1'b0, "R1 event/irq", {txb_event, irq}, 0);
        check(wr_ready === 1'b1, "R1 wr_ready", wr_ready, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table of frames, two bytes each in one buffer
        for (int v = 0; v < 6; v++) begin
            cts = 1'b0;
            extra_flags = VEC[v][19:16];
            fb[0] = VEC[v][15:8];
            fb[1] = VEC[v][7:0];
            pulse_clear();
            start_cap();
            push_byte(fb[0], 1'b0, 1'b0, 1'b0, 1'b0);
            push_byte(fb[1], 1'b1, 1'b1, v[0], 1'b0);
            run_check(2, int'(VEC[v][19:16]), v[0]);
        end

        // R2: handshake wait
        cts = 1'b0; extra_flags = 4'd0; fb[0] = 8'h55;
        pulse_clear();
        start_cap();
        push_byte(fb[0], 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        zeros = 0;
        for (int k = 0; k < ncap; k++) if (cap_bit[k] == 1'b0) zeros++;
        check(rts === 1'b1, "R2 rts raised for held frame", rts, 1);
        check(zeros == 0, "R2 no flag before cts", zeros, 0);
        run_check(1, 0, 1'b0);

        // R7 R9 R10 R11: buffer events inside a frame
        cts = 1'b0; extra_flags = 4'd2;
        fb[0] = 8'h81; fb[1] = 8'hBE; fb[2] = 8'hFC;
        start_cap();
        push_byte(fb[0], 1'b1, 1'b0, 1'b1, 1'b0);
        check(txb_event === 1'b1, "R7 mid-frame buffer event", txb_event, 1);
        check(irq === 1'b0, "R11 masked irq", irq, 0);
        check(rts === 1'b0, "R2 incomplete frame not started", rts, 0);
        @(negedge clk); mask_we = 1'b1; mask_wd = 1'b1;
        @(negedge clk); mask_we = 1'b0;
        check(irq === 1'b1, "R11 unmasked irq", irq, 1);
        pulse_clear();
        check(txb_event === 1'b0 && irq === 1'b0, "R10 write-one clear",
              {txb_event, irq}, 0);
        push_byte(fb[1], 1'b1, 1'b0, 1'b1, 1'b1);
        check(txb_event === 1'b1, "R10 set wins over clear", txb_event, 1);
        pulse_clear();
        push_byte(fb[2], 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check(txb_event === 1'b0, "R9 no event without enable", txb_event, 0);
        fb[3] = 8'h1F;
        push_byte(fb[3], 1'b1, 1'b1, 1'b1, 1'b0);
        run_check(4, 2, 1'b1);
        check(irq === 1'b1, "R11 irq from last-buffer event", irq, 1);

        // R12: fill queue with an unfinished frame
        cts = 1'b0;
        for (int i = 0; i < DEPTH; i++) push_byte(8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
        check(wr_ready === 1'b0, "R12 full", wr_ready, 0);
        check(rts === 1'b0, "R2 no start without frame end", rts, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(wr_ready === 1'b1 && txb_event === 1'b0 && irq === 1'b0,
              "R1 reset clears state", {wr_ready, txb_event, irq}, 4);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule